// File: doc/BRIEF.md
# Serial GPIO Master Controller

This block turns four serial pins into a large set of general-purpose inputs and outputs. An external chain of shift registers holds the real pins. The controller clocks that chain without a break. In each frame it first pulses a load strobe, then shifts out one output bit per serial pin position, and at the same time it captures one input bit per position. Each pin position therefore carries one input line and one output line. Logical line `2p` is the input of position `p` and line `2p+1` is its output, so the logical line count is twice the pin count.

Software uses a plain register bus. A request is `bus_sel` together with `bus_wr`. Writes complete in the cycle they are presented. Read data appears on `bus_rdata` in the cycle after the request. There is no back-pressure: every request is accepted at once. One control register holds the enable bit, the pin count in groups of eight, and a 16-bit clock divider. Each bank of 32 pin positions has two registers. The data register reads the input image and takes writes for the output latches. The readback register returns the output latches.

Top module: `sgpm_master`

## Requirements
- R1: After reset, every register reads zero, and `ser_clk`, `ser_load` and `ser_dout` are low.
- R2: The control register is at offset 0x54. Bit 0 is enable, bits 10:6 are the pin count in groups of eight, and bits 31:16 are the clock divider. Reads return these fields, and all other bits read as zero.
- R3: While running, `ser_clk` is low for divider+1 bus clock cycles and then high for divider+1 cycles, so its frequency is the bus clock divided by 2*(divider+1).
- R4: A frame is N+1 serial clock periods long, where N = 8*groups. The first period has `ser_load` high. Frames follow one another with no gap, so a new load period starts every (N+1)*2*(divider+1) cycles.
- R5: In the k-th data period of a frame (k = 1..N), `ser_dout` carries the output latch of pin position k-1. It is low during the load period, and it changes only while `ser_clk` is low.
- R6: `ser_din` is sampled on the rising `ser_clk` edge of the k-th data period and becomes the input bit of pin position k-1.
- R7: The input image is replaced as a whole when a frame completes, and positions at or above N read as zero. The data registers of banks 0..3 are at offsets 0x00, 0x1C, 0x38 and 0x90. Bit i of bank b is pin position 32b+i, which is logical line 2(32b+i) for the input and 2(32b+i)+1 for the output.
- R8: Writing a data register sets the 32 output latches of that bank. The readback registers at 0x70, 0x74, 0x78 and 0x7C return the latches of banks 0..3.
- R9: Clearing enable brings `ser_clk`, `ser_load` and `ser_dout` low on the next cycle. The frame in progress is dropped without touching the input image. After enable is set again, the first serial period is a load period.
- R10: A pin count of zero produces no serial activity. A count above 16 groups behaves as 16 groups (128 positions).
- R11: Reads of unmapped offsets return zero. Writes to readback or unmapped offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access request |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read request |
| ser_clk | output | 1 | Serial clock to the shift-register chain |
| ser_load | output | 1 | Frame load strobe, high for one serial period |
| ser_dout | output | 1 | Serial output data |
| ser_din | input | 1 | Serial input data from the chain |

## Verification
The hardest case to reach from the ports is a frame that is dropped part way through. It must leave the previous input image in place even though the chain has already delivered new bits. The stimulus waits for a load strobe and then swaps the chain's input pattern. It clears enable a few dozen cycles into the frame, well before the frame can complete. Reading the data registers must then return the old pattern. Re-enabling must start with a load period and afterwards deliver the new pattern. Random pin counts and dividers are mixed with directed runs at zero, full and over-range counts. These check frame length, the zeroing of unused positions, and the per-position bit order.

// File: rtl/sgpm_pkg.sv
package sgpm_pkg;
  localparam logic [7:0] CTRL_OFF  = 8'h54;
  localparam int         EN_BIT    = 0;
  localparam int         PCNT_LSB  = 6;
  localparam int         DIV_LSB   = 16;
  localparam int         BANK_BITS = 32;

  // Offset of the data register for a bank of 32 pin positions
  function automatic logic [7:0] data_off(input int bank);
    case (bank)
      0:       data_off = 8'h00;
      1:       data_off = 8'h1C;
      2:       data_off = 8'h38;
      default: data_off = 8'h90;
    endcase
  endfunction

  // Offset of the output readback register for a bank
  function automatic logic [7:0] rb_off(input int bank);
    rb_off = 8'h70 + 8'(bank * 4);
  endfunction
endpackage

// File: rtl/sgpm_clkgen.sv
module sgpm_clkgen #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [DIV_W-1:0] div,
  output logic             ser_clk,
  output logic             tick_rise,
  output logic             tick_fall
);
  logic [DIV_W-1:0] cnt_q;
  logic             phase_q;
  logic             half_done;

  // >= keeps a shrinking divider from stalling the current half period
  assign half_done = en && (cnt_q >= div);
  assign tick_rise = half_done && !phase_q;
  assign tick_fall = half_done && phase_q;
  assign ser_clk   = phase_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      phase_q <= 1'b0;
    end else if (!en) begin
      cnt_q   <= '0;
      phase_q <= 1'b0;
    end else if (half_done) begin
      cnt_q   <= '0;
      phase_q <= ~phase_q;
    end else begin
      cnt_q   <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/sgpm_frame.sv
module sgpm_frame #(
  parameter int MAX_PINS = 128,
  parameter int SLOT_W   = $clog2(MAX_PINS + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                run,
  input  logic [SLOT_W-1:0]   npins,
  input  logic                tick_rise,
  input  logic                tick_fall,
  input  logic [MAX_PINS-1:0] out_latch,
  input  logic                ser_din,
  output logic                clk_en,
  output logic                ser_load,
  output logic                ser_dout,
  output logic [MAX_PINS-1:0] in_image
);
  localparam int IDX_W = $clog2(MAX_PINS);

  logic [SLOT_W-1:0]   slot_q, slot_nxt;
  logic [MAX_PINS-1:0] samp_q;
  logic [MAX_PINS-1:0] lane_mask;
  logic                active_q;
  logic                load_q, dout_q;
  logic                frame_end;
  logic [IDX_W-1:0]    cur_idx, nxt_idx;

  // The serial clock starts one cycle after the load strobe, so the strobe
  // is settled before the first rising edge reaches the chain.
  assign clk_en    = run && active_q;
  assign frame_end = tick_fall && (slot_q >= npins);
  assign cur_idx   = IDX_W'(slot_q - SLOT_W'(1));
  assign nxt_idx   = IDX_W'(slot_nxt - SLOT_W'(1));
  assign ser_load  = load_q;
  assign ser_dout  = dout_q;

  always_comb begin
    slot_nxt = slot_q;
    if (!run)           slot_nxt = '0;
    else if (frame_end) slot_nxt = '0;
    else if (tick_fall) slot_nxt = slot_q + 1'b1;
  end

  always_comb begin
    for (int i = 0; i < MAX_PINS; i++) lane_mask[i] = (SLOT_W'(i) < npins);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q   <= '0;
      active_q <= 1'b0;
      load_q   <= 1'b0;
      dout_q   <= 1'b0;
      samp_q   <= '0;
      in_image <= '0;
    end else begin
      slot_q   <= slot_nxt;
      active_q <= run;
      load_q   <= run && (slot_nxt == '0);
      if (!run)
        dout_q <= 1'b0;
      else if (tick_fall)
        dout_q <= (slot_nxt != '0) ? out_latch[nxt_idx] : 1'b0;
      if (run && tick_rise && (slot_q != '0))
        samp_q[cur_idx] <= ser_din;
      if (run && frame_end && (slot_q != '0))
        in_image <= samp_q & lane_mask;
    end
  end
endmodule

// File: rtl/sgpm_regs.sv
module sgpm_regs
  import sgpm_pkg::*;
#(
  parameter int MAX_PINS = 128,
  parameter int PCNT_W   = 5,
  parameter int DIV_W    = 16,
  parameter int NBANK    = (MAX_PINS + BANK_BITS - 1) / BANK_BITS
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_sel,
  input  logic                bus_wr,
  input  logic [7:0]          bus_addr,
  input  logic [31:0]         bus_wdata,
  output logic [31:0]         bus_rdata,
  input  logic [MAX_PINS-1:0] in_image,
  output logic                ctrl_en,
  output logic [PCNT_W-1:0]   ctrl_pcnt,
  output logic [DIV_W-1:0]    ctrl_div,
  output logic [MAX_PINS-1:0] out_latch
);
  localparam int PAD_W = NBANK * BANK_BITS;

  logic [PAD_W-1:0] image_pad, latch_pad;
  logic [31:0]      rd_val;

  always_comb begin
    image_pad = '0;
    latch_pad = '0;
    image_pad[MAX_PINS-1:0] = in_image;
    latch_pad[MAX_PINS-1:0] = out_latch;
  end

  always_comb begin
    rd_val = '0;
    if (bus_addr == CTRL_OFF) begin
      rd_val[EN_BIT]               = ctrl_en;
      rd_val[PCNT_LSB +: PCNT_W]   = ctrl_pcnt;
      rd_val[DIV_LSB +: DIV_W]     = ctrl_div;
    end
    for (int b = 0; b < NBANK; b++) begin
      if (bus_addr == data_off(b)) rd_val = image_pad[b*BANK_BITS +: BANK_BITS];
      if (bus_addr == rb_off(b))   rd_val = latch_pad[b*BANK_BITS +: BANK_BITS];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_en   <= 1'b0;
      ctrl_pcnt <= '0;
      ctrl_div  <= '0;
      out_latch <= '0;
      bus_rdata <= '0;
    end else begin
      bus_rdata <= (bus_sel && !bus_wr) ? rd_val : '0;
      if (bus_sel && bus_wr) begin
        if (bus_addr == CTRL_OFF) begin
          ctrl_en   <= bus_wdata[EN_BIT];
          ctrl_pcnt <= bus_wdata[PCNT_LSB +: PCNT_W];
          ctrl_div  <= bus_wdata[DIV_LSB +: DIV_W];
        end
        for (int i = 0; i < MAX_PINS; i++)
          if (bus_addr == data_off(i / BANK_BITS))
            out_latch[i] <= bus_wdata[i % BANK_BITS];
      end
    end
  end
endmodule

// File: rtl/sgpm_master.sv
module sgpm_master
  import sgpm_pkg::*;
#(
  parameter int MAX_PINS = 128,
  parameter int PCNT_W   = 5,
  parameter int DIV_W    = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_sel,
  input  logic        bus_wr,
  input  logic [7:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        ser_clk,
  output logic        ser_load,
  output logic        ser_dout,
  input  logic        ser_din
);
  localparam int SLOT_W  = $clog2(MAX_PINS + 1);
  localparam int MAX_GRP = MAX_PINS / 8;

  logic                ctrl_en;
  logic [PCNT_W-1:0]   ctrl_pcnt, groups;
  logic [DIV_W-1:0]    ctrl_div;
  logic [MAX_PINS-1:0] out_latch, in_image;
  logic [SLOT_W-1:0]   npins;
  logic                run, clk_en, tick_rise, tick_fall;

  // Over-range counts saturate at the largest supported chain
  assign groups = (ctrl_pcnt > PCNT_W'(MAX_GRP)) ? PCNT_W'(MAX_GRP) : ctrl_pcnt;
  assign npins  = SLOT_W'({groups, 3'b000});
  assign run    = ctrl_en && (groups != '0);

  sgpm_regs #(
    .MAX_PINS(MAX_PINS), .PCNT_W(PCNT_W), .DIV_W(DIV_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .in_image(in_image),
    .ctrl_en(ctrl_en), .ctrl_pcnt(ctrl_pcnt), .ctrl_div(ctrl_div),
    .out_latch(out_latch)
  );

  sgpm_clkgen #(.DIV_W(DIV_W)) u_clkgen (
    .clk(clk), .rst_n(rst_n), .en(clk_en), .div(ctrl_div),
    .ser_clk(ser_clk), .tick_rise(tick_rise), .tick_fall(tick_fall)
  );

  sgpm_frame #(.MAX_PINS(MAX_PINS), .SLOT_W(SLOT_W)) u_frame (
    .clk(clk), .rst_n(rst_n), .run(run), .npins(npins),
    .tick_rise(tick_rise), .tick_fall(tick_fall),
    .out_latch(out_latch), .ser_din(ser_din),
    .clk_en(clk_en), .ser_load(ser_load), .ser_dout(ser_dout),
    .in_image(in_image)
  );
endmodule

// File: rtl/sgpm_master_chk.sv
module sgpm_master_chk #(
  parameter int DIV_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run,
  input logic [DIV_W-1:0] div,
  input logic             ser_clk,
  input logic             ser_load,
  input logic             ser_dout
);
  logic [DIV_W:0]   hp_q;
  logic             clk_prev_q, armed_q;
  logic [DIV_W-1:0] div_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hp_q       <= '0;
      clk_prev_q <= 1'b0;
      armed_q    <= 1'b0;
      div_q      <= '0;
    end else begin
      clk_prev_q <= ser_clk;
      div_q      <= div;
      hp_q       <= (ser_clk != clk_prev_q) ? '0 : hp_q + 1'b1;
      if (!run || (div != div_q)) armed_q <= 1'b0;
      else if (ser_clk != clk_prev_q) armed_q <= 1'b1;
    end
  end

  a_r3_half_period: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && run && (div == div_q) && (ser_clk != clk_prev_q)) |-> (hp_q == {1'b0, div}));

  a_r9_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (!ser_clk && !ser_load && !ser_dout));

  a_r5_dout_low_in_load: assert property (@(posedge clk) disable iff (!rst_n)
    ser_load |-> !ser_dout);

  a_r5_dout_moves_low: assert property (@(posedge clk) disable iff (!rst_n)
    $changed(ser_dout) |-> !ser_clk);

  a_r4_load_rise_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ser_load) |-> !ser_clk);

  a_r4_load_fall_low: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ser_load) |-> !ser_clk);
endmodule

bind sgpm_master sgpm_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .run(run), .div(ctrl_div),
  .ser_clk(ser_clk), .ser_load(ser_load), .ser_dout(ser_dout)
);

// File: tb/sgpm_master_tb.sv
module sgpm_master_tb;
  localparam int MAXP = 128;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        ser_clk, ser_load, ser_dout;
  logic        ser_din = 1'b0;

  int checks = 0, failures = 0;
  bit done = 1'b0;
  logic [MAXP-1:0] ext_in = '0, ext_a = '0, lat = '0, cap_out = '0, last_out = '0;
  int ptr = 0, frame_cnt = 0, cyc = 0, last_rise = 0, last_load = 0, period = 0, frame_len = 0;

  sgpm_master u_dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ser_clk(ser_clk), .ser_load(ser_load), .ser_dout(ser_dout), .ser_din(ser_din)
  );

  always #2 clk = ~clk;
  always @(posedge clk) cyc++;

  // Behavioural external chain: parallel load on the strobe, then shift
  always @(posedge ser_clk) begin
    period    = cyc - last_rise;
    last_rise = cyc;
    if (ser_load) begin
      frame_len = cyc - last_load;
      last_load = cyc;
      last_out  = cap_out;
      frame_cnt++;
      ptr       = 0;
      ser_din   = ext_in[0];
    end else begin
      if (ptr < MAXP) cap_out[ptr] = ser_dout;
      ptr++;
      ser_din = (ptr < MAXP) ? ext_in[ptr] : 1'b0;
    end
  end

  function automatic logic [7:0] doff(input int b);
    case (b)
      0: doff = 8'h00;
      1: doff = 8'h1C;
      2: doff = 8'h38;
      default: doff = 8'h90;
    endcase
  endfunction

  function automatic logic [31:0] mk_ctrl(input bit en, input int grp, input int dv);
    mk_ctrl = (32'(dv) << 16) | ((32'(grp) & 32'h1F) << 6) | 32'(en);
  endfunction

  function automatic logic [31:0] bank_of(input logic [MAXP-1:0] v, input int b, input int n);
    logic [31:0] r;
    for (int i = 0; i < 32; i++) r[i] = (32*b + i < n) ? v[32*b + i] : 1'b0;
    return r;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk); bus_sel = 1'b0; d = bus_rdata;
  endtask

  task automatic wait_frames(input int k);
    int s;
    s = frame_cnt;
    while (frame_cnt < s + k) @(negedge clk);
  endtask

  task automatic set_latches();
    for (int b = 0; b < 4; b++) bus_write(doff(b), lat[32*b +: 32]);
  endtask

  // R3/R4 timing, R5 output order, R6/R7 input image
  task automatic check_frame(input string tag, input int n, input int dv);
    logic [31:0] rd;
    for (int b = 0; b < 4; b++) begin
      bus_read(doff(b), rd);
      chk({tag, " R6_R7 image"}, rd, bank_of(ext_in, b, n));
      chk({tag, " R5 dout"}, bank_of(last_out, b, n), bank_of(lat, b, n));
    end
    chk({tag, " R3 period"}, 32'(period), 32'(2 * (dv + 1)));
    chk({tag, " R4 frame_len"}, 32'(frame_len), 32'((n + 1) * 2 * (dv + 1)));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    int s;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 pins", {29'd0, ser_clk, ser_load, ser_dout}, 32'd0);
    bus_read(8'h54, rd); chk("R1 ctrl", rd, 32'd0);
    bus_read(8'h00, rd); chk("R1 data0", rd, 32'd0);
    bus_read(8'h7C, rd); chk("R1 rb3", rd, 32'd0);

    // R2 control fields, other bits read zero
    bus_write(8'h54, 32'hFFFF_FFFE);
    bus_read(8'h54, rd); chk("R2 ctrl mask", rd, 32'hFFFF_07C0);
    bus_write(8'h54, 32'd0);

    // R11 unmapped read
    bus_read(8'h04, rd); chk("R11 unmapped", rd, 32'd0);

    // R8 latches and readback
    lat = {$urandom, $urandom, $urandom, $urandom};
    set_latches();
    for (int b = 0; b < 4; b++) begin
      bus_read(8'h70 + 8'(4 * b), rd);
      chk("R8 readback", rd, lat[32*b +: 32]);
    end
    bus_write(8'h70, ~lat[31:0]);
    bus_write(8'h60, 32'hFFFF_FFFF);
    bus_read(8'h70, rd); chk("R11 rb write ignored", rd, lat[31:0]);
    bus_read(8'h00, rd); chk("R11 data0 untouched", rd, 32'd0);

    // Full chain, divider 1
    ext_in = {$urandom, $urandom, $urandom, $urandom};
    bus_write(8'h54, mk_ctrl(1, 16, 1));
    wait_frames(3);
    check_frame("full", 128, 1);

    // R10 over-range count saturates at 128 positions
    bus_write(8'h54, 32'd0);
    ext_in = {$urandom, $urandom, $urandom, $urandom};
    bus_write(8'h54, mk_ctrl(1, 20, 0));
    wait_frames(3);
    check_frame("R10 clamp", 128, 0);

    // R7 short chain, unused positions read zero
    bus_write(8'h54, 32'd0);
    ext_in = {$urandom, $urandom, $urandom, $urandom};
    bus_write(8'h54, mk_ctrl(1, 2, 2));
    wait_frames(3);
    check_frame("R7 short", 16, 2);

    // R10 zero count stays idle
    bus_write(8'h54, mk_ctrl(1, 0, 0));
    @(negedge clk);
    s = frame_cnt;
    repeat (600) @(negedge clk);
    chk("R10 zero no frames", 32'(frame_cnt), 32'(s));
    chk("R10 zero clk low", {31'd0, ser_clk}, 32'd0);

    // R9 abandon a frame part way through
    bus_write(8'h54, 32'd0);
    ext_in = {$urandom, $urandom, $urandom, $urandom};
    ext_a  = ext_in;
    bus_write(8'h54, mk_ctrl(1, 16, 3));
    wait_frames(3);
    wait_frames(1);
    ext_in = ~ext_a;
    repeat (40) @(negedge clk);
    bus_write(8'h54, mk_ctrl(0, 16, 3));
    @(negedge clk);
    chk("R9 pins low", {29'd0, ser_clk, ser_load, ser_dout}, 32'd0);
    for (int b = 0; b < 4; b++) begin
      bus_read(doff(b), rd);
      chk("R9 image kept", rd, bank_of(ext_a, b, 128));
    end
    bus_write(8'h54, mk_ctrl(1, 16, 3));
    @(posedge ser_clk);
    #1;
    chk("R9 restart with load", {31'd0, ser_load}, 32'd1);
    wait_frames(3);
    check_frame("R9 resume", 128, 3);

    // Random configurations
    for (int it = 0; it < 6; it++) begin
      int g, dv;
      bus_write(8'h54, 32'd0);
      ext_in = {$urandom, $urandom, $urandom, $urandom};
      lat    = {$urandom, $urandom, $urandom, $urandom};
      set_latches();
      g  = 1 + int'($urandom % 16);
      dv = int'($urandom % 3);
      bus_write(8'h54, mk_ctrl(1, g, dv));
      wait_frames(3);
      check_frame("rand", 8 * g, dv);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule